// File: doc/BRIEF.md
# Dual-Issue Dispatch and Completion Tracker

This block sits between instruction fetch and the issue stage of an in-order-completing core. Fetch writes up to four decoded instructions per clock into a small circular instruction buffer. Each instruction carries only one bit here: whether it is a branch. Every clock, up to two instructions leave the head of that buffer in program order. Branches go to a branch issue queue, which takes at most one per clock. All other instructions go to a general issue queue, which takes up to two per clock. Each dispatched instruction takes the next entry of a 14-entry completion ring, and the index of that entry is its tag.

Execution units report finished work by tag. Branch outcomes arrive on a separate resolve port. Entries leave the ring in program order, up to two per clock. A branch entry may leave only after it has been resolved. When a branch resolves as mispredicted, every ring entry younger than the branch is discarded and the instruction buffer is emptied. A one-cycle flush pulse is then raised for the rest of the pipeline.

Top module: `dual_dispatch_cq`

## Requirements
- R1: After reset, no enqueue, retire or flush strobe is active and `fetchRdy` is high. The first instruction dispatched receives tag 0.
- R2: When `fetchCnt` is n (0 to 4), n instructions are written into the instruction buffer in one clock. Bit i of `fetchBr` marks the i-th oldest of them as a branch. `fetchRdy` is high exactly when at least four buffer slots are free.
- R3: Up to two instructions are dispatched per clock from the buffer head, strictly in program order. Tags are assigned consecutively modulo 14. Enqueue strobes are valid in the clock in which the instructions sit at the head.
- R4: The general queue receives up to two instructions per clock. `genEnq` lanes fill from lane 0, and lane 0 carries the older instruction. `genEnq` is 2'b11 for two instructions, 2'b01 for one and 2'b00 for none.
- R5: The branch queue receives at most one instruction per clock. When two branches are at the head, the younger one waits for the next clock.
- R6: When the older head instruction cannot be placed, the younger one is held too. An instruction cannot be placed when its target queue's full flag is high or the completion ring is full.
- R7: The completion ring never holds more than 14 entries. With 13 entries occupied, only one instruction is dispatched.
- R8: Up to two entries retire per clock, only from the ring head and in program order. The second retires only if the head retires in the same clock. Retire strobes appear the clock after the finishing report.
- R9: A finish report marks a non-branch entry as done. A finish report addressed to a branch entry is ignored. A branch entry becomes done only through the resolve port, whether the branch was predicted correctly or not.
- R10: A mispredict resolve discards all ring entries younger than the branch and empties the instruction buffer. The next allocated tag is the branch tag plus one. No dispatch and no fetch write happens in that clock.
- R11: `flush` is high for exactly one clock, the clock after a mispredict resolve.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchCnt | input | 3 | Number of instructions written this clock (0 to 4) |
| fetchBr | input | 4 | Branch marker per written instruction, bit 0 oldest |
| fetchRdy | output | 1 | At least four buffer slots are free |
| brFull | input | 1 | Branch issue queue cannot accept |
| genFull | input | 1 | General issue queue cannot accept |
| brEnq | output | 1 | Branch enqueue strobe |
| brTag | output | 4 | Tag of the enqueued branch |
| genEnq | output | 2 | General enqueue lane strobes |
| genTag0 | output | 4 | Tag on general lane 0 (older) |
| genTag1 | output | 4 | Tag on general lane 1 |
| finVld | input | 2 | Finish report valid, one bit per report port |
| finTag | input | 8 | Finish tags, port k in bits 4k+3 to 4k |
| resVld | input | 1 | Branch resolve valid |
| resMiss | input | 1 | Resolved branch was mispredicted |
| resTag | input | 4 | Tag of the resolved branch |
| retVld | output | 2 | Retire strobes, bit 0 for the head entry |
| retTag0 | output | 4 | Tag of the head entry |
| retTag1 | output | 4 | Tag of the entry behind the head |
| flush | output | 1 | One-clock flush pulse after a mispredict |

## Verification
A corrupted ring tail pointer shows up in the same clock as a wrong tag on the next enqueue strobe. A corrupted head pointer or done bit shows up one clock after the relevant finish report, as a missing, early or out-of-order retire strobe. A wrong occupancy count shows up as dispatch past a full ring or as a stall that never clears. It also leaves a mismatch between the tags dispatched and the tags retired, which the bench sees once the run drains. After a mispredict, a buffer that was not emptied reveals itself within a clock as dispatches that should never happen.

// File: rtl/dd_pkg.sv
package dd_pkg;
  parameter int IQ_DEPTH = 8;
  parameter int CQ_DEPTH = 14;
  parameter int FETCH_W  = 4;
  parameter int FIN_N    = 2;

  localparam int TAG_W = $clog2(CQ_DEPTH);
  localparam int IQ_PW = $clog2(IQ_DEPTH);
  localparam int IQ_CW = $clog2(IQ_DEPTH + 1);
  localparam int CQ_CW = $clog2(CQ_DEPTH + 1);
  localparam int FC_W  = $clog2(FETCH_W + 1);

  // control -> datapath strobes
  typedef struct packed {
    logic [FC_W-1:0]  pushN;
    logic [1:0]       popN;
    logic [1:0]       retN;
    logic             flush;
    logic             resDone;
    logic [TAG_W-1:0] resTag;
  } strobe_t;

  // datapath -> control state view
  typedef struct packed {
    logic [IQ_CW-1:0] iqCnt;
    logic [1:0]       headBr;
    logic [CQ_CW-1:0] cqCnt;
    logic [TAG_W-1:0] cqTail;
    logic [TAG_W-1:0] cqTail1;
    logic [TAG_W-1:0] cqHead;
    logic [TAG_W-1:0] cqHead1;
    logic [1:0]       headDone;
  } status_t;
endpackage

// File: rtl/dd_path.sv
module dd_path
  import dd_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                strb,
  input  logic [FETCH_W-1:0]     fetchBr,
  input  logic [FIN_N-1:0]       finVld,
  input  logic [FIN_N*TAG_W-1:0] finTag,
  output status_t                stat
);
  logic             iqBr   [IQ_DEPTH];
  logic [IQ_PW-1:0] iqHead, iqTail;
  logic [IQ_CW-1:0] iqCnt;
  logic             cqDone [CQ_DEPTH];
  logic             cqBr   [CQ_DEPTH];
  logic [TAG_W-1:0] cqHead, cqTail;
  logic [CQ_CW-1:0] cqCnt;

  function automatic logic [IQ_PW-1:0] iqWrap(int p);
    return IQ_PW'(p % IQ_DEPTH);
  endfunction

  function automatic logic [TAG_W-1:0] cqWrap(int p);
    return TAG_W'(p % CQ_DEPTH);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      iqHead <= '0;
      iqTail <= '0;
      iqCnt  <= '0;
      cqHead <= '0;
      cqTail <= '0;
      cqCnt  <= '0;
      for (int i = 0; i < IQ_DEPTH; i++) iqBr[i] <= 1'b0;
      for (int i = 0; i < CQ_DEPTH; i++) begin
        cqDone[i] <= 1'b0;
        cqBr[i]   <= 1'b0;
      end
    end else begin
      // instruction buffer
      for (int i = 0; i < FETCH_W; i++)
        if (i < int'(strb.pushN)) iqBr[iqWrap(int'(iqTail) + i)] <= fetchBr[i];
      iqHead <= iqWrap(int'(iqHead) + int'(strb.popN));
      if (strb.flush) begin
        iqTail <= iqHead;
        iqCnt  <= '0;
      end else begin
        iqTail <= iqWrap(int'(iqTail) + int'(strb.pushN));
        iqCnt  <= iqCnt + IQ_CW'(strb.pushN) - IQ_CW'(strb.popN);
      end
      // completion ring: done marking
      for (int f = 0; f < FIN_N; f++)
        if (finVld[f] && !cqBr[finTag[f*TAG_W +: TAG_W]])
          cqDone[finTag[f*TAG_W +: TAG_W]] <= 1'b1;
      if (strb.resDone) cqDone[strb.resTag] <= 1'b1;
      // completion ring: allocation
      for (int k = 0; k < 2; k++)
        if (k < int'(strb.popN)) begin
          cqDone[cqWrap(int'(cqTail) + k)] <= 1'b0;
          cqBr[cqWrap(int'(cqTail) + k)]   <= stat.headBr[k];
        end
      cqHead <= cqWrap(int'(cqHead) + int'(strb.retN));
      if (strb.flush) begin
        cqTail <= cqWrap(int'(strb.resTag) + 1);
        cqCnt  <= CQ_CW'(cqWrap(int'(strb.resTag) + CQ_DEPTH - int'(cqHead)))
                  + CQ_CW'(1) - CQ_CW'(strb.retN);
      end else begin
        cqTail <= cqWrap(int'(cqTail) + int'(strb.popN));
        cqCnt  <= cqCnt + CQ_CW'(strb.popN) - CQ_CW'(strb.retN);
      end
    end
  end

  always_comb begin
    stat.iqCnt    = iqCnt;
    stat.headBr   = {iqBr[iqWrap(int'(iqHead) + 1)], iqBr[iqHead]};
    stat.cqCnt    = cqCnt;
    stat.cqTail   = cqTail;
    stat.cqTail1  = cqWrap(int'(cqTail) + 1);
    stat.cqHead   = cqHead;
    stat.cqHead1  = cqWrap(int'(cqHead) + 1);
    stat.headDone = {cqDone[cqWrap(int'(cqHead) + 1)], cqDone[cqHead]};
  end

  // R7
  cq_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.popN != 2'd0) |-> (int'(cqCnt) + int'(strb.popN) <= CQ_DEPTH));
  // R8
  ret_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.retN != 2'd0) |-> cqDone[cqHead]);
  // R2
  iq_room_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pushN != '0) |-> (int'(iqCnt) + int'(strb.pushN) <= IQ_DEPTH));
  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> (iqCnt == '0));
endmodule

// File: rtl/dd_ctrl.sv
module dd_ctrl
  import dd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  status_t          stat,
  input  logic [FC_W-1:0]  fetchCnt,
  output logic             fetchRdy,
  input  logic             brFull,
  input  logic             genFull,
  output logic             brEnq,
  output logic [TAG_W-1:0] brTag,
  output logic [1:0]       genEnq,
  output logic [TAG_W-1:0] genTag0,
  output logic [TAG_W-1:0] genTag1,
  input  logic             resVld,
  input  logic             resMiss,
  input  logic [TAG_W-1:0] resTag,
  output logic [1:0]       retVld,
  output logic [TAG_W-1:0] retTag0,
  output logic [TAG_W-1:0] retTag1,
  output logic             flush,
  output strobe_t          strb
);
  logic flushNow, hb0, hb1, d0, d1, b0, b1, g0, g1, r0, r1, fits, flushQ;

  always_comb begin
    hb0      = stat.headBr[0];
    hb1      = stat.headBr[1];
    flushNow = resVld & resMiss;
    // in-order dual dispatch
    d0 = !flushNow && (stat.iqCnt != '0) && (int'(stat.cqCnt) < CQ_DEPTH)
         && (hb0 ? !brFull : !genFull);
    d1 = d0 && (int'(stat.iqCnt) >= 2) && (int'(stat.cqCnt) < CQ_DEPTH - 1)
         && (hb1 ? (!hb0 && !brFull) : !genFull);
    b0 = d0 & hb0;
    b1 = d1 & hb1;
    g0 = d0 & ~hb0;
    g1 = d1 & ~hb1;
    brEnq   = b0 | b1;
    brTag   = b0 ? stat.cqTail : stat.cqTail1;
    genEnq  = {g0 & g1, g0 | g1};
    genTag0 = g0 ? stat.cqTail : stat.cqTail1;
    genTag1 = stat.cqTail1;
    // in-order retirement
    r0 = (stat.cqCnt != '0) && stat.headDone[0];
    r1 = r0 && (int'(stat.cqCnt) >= 2) && stat.headDone[1];
    retVld  = {r1, r0};
    retTag0 = stat.cqHead;
    retTag1 = stat.cqHead1;
    // fetch side
    fetchRdy = int'(stat.iqCnt) <= IQ_DEPTH - FETCH_W;
    fits     = int'(fetchCnt) <= IQ_DEPTH - int'(stat.iqCnt);
    strb.pushN   = (!flushNow && fits) ? fetchCnt : '0;
    strb.popN    = {1'b0, d0} + {1'b0, d1};
    strb.retN    = {1'b0, r0} + {1'b0, r1};
    strb.flush   = flushNow;
    strb.resDone = resVld;
    strb.resTag  = resTag;
    flush = flushQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) flushQ <= 1'b0;
    else       flushQ <= flushNow;
  end

  // R4
  gen_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    genFull |-> (genEnq == 2'b00));
  // R5
  br_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    brFull |-> !brEnq);
  // R10
  flush_nodisp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resVld && resMiss) |-> (!brEnq && genEnq == 2'b00));
  // R11
  flush_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resVld && resMiss) |=> flush);
endmodule

// File: rtl/dual_dispatch_cq.sv
module dual_dispatch_cq
  import dd_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [FC_W-1:0]        fetchCnt,
  input  logic [FETCH_W-1:0]     fetchBr,
  output logic                   fetchRdy,
  input  logic                   brFull,
  input  logic                   genFull,
  output logic                   brEnq,
  output logic [TAG_W-1:0]       brTag,
  output logic [1:0]             genEnq,
  output logic [TAG_W-1:0]       genTag0,
  output logic [TAG_W-1:0]       genTag1,
  input  logic [FIN_N-1:0]       finVld,
  input  logic [FIN_N*TAG_W-1:0] finTag,
  input  logic                   resVld,
  input  logic                   resMiss,
  input  logic [TAG_W-1:0]       resTag,
  output logic [1:0]             retVld,
  output logic [TAG_W-1:0]       retTag0,
  output logic [TAG_W-1:0]       retTag1,
  output logic                   flush
);
  strobe_t strb;
  status_t stat;

  dd_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .stat(stat), .fetchCnt(fetchCnt), .fetchRdy(fetchRdy),
    .brFull(brFull), .genFull(genFull), .brEnq(brEnq), .brTag(brTag),
    .genEnq(genEnq), .genTag0(genTag0), .genTag1(genTag1),
    .resVld(resVld), .resMiss(resMiss), .resTag(resTag),
    .retVld(retVld), .retTag0(retTag0), .retTag1(retTag1),
    .flush(flush), .strb(strb)
  );

  dd_path uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .fetchBr(fetchBr),
    .finVld(finVld), .finTag(finTag), .stat(stat)
  );
endmodule

// File: tb/sim_dual_dispatch_cq.sv
`timescale 1ns/1ps
module sim_dual_dispatch_cq;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] fetchCnt = '0;
  logic [3:0] fetchBr = '0;
  logic       fetchRdy, brFull = 1'b0, genFull = 1'b0;
  logic       brEnq;
  logic [3:0] brTag, genTag0, genTag1, retTag0, retTag1;
  logic [1:0] genEnq, retVld;
  logic [1:0] finVld = '0;
  logic [7:0] finTag = '0;
  logic       resVld = 1'b0, resMiss = 1'b0;
  logic [3:0] resTag = '0;
  logic       flush;

  dual_dispatch_cq u0 (.*);

  always #5 clk = ~clk;

  int nVec = 0, nBad = 0, nextTag = 0, dispSeen = 0;
  int dq[$];   // expected dispatch: branch*16 + tag, program order
  int rq[$];   // expected retire tags, program order
  bit ended = 0;

  task automatic check(string req, int act, int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic look();
    @(negedge clk);
  endtask

  task automatic fetchGrp(int n, logic [3:0] br);
    for (int i = 0; i < n; i++) begin
      dq.push_back(int'(br[i]) * 16 + nextTag);
      nextTag = (nextTag + 1) % 14;
    end
    fetchCnt = 3'(n);
    fetchBr  = br;
    step();
    fetchCnt = '0;
    fetchBr  = '0;
  endtask

  // scoreboard monitor
  int mn, mgi, mv, mebt;
  bit meb;
  int meg[2];
  always @(negedge clk) if (rstN) begin
    mn = int'(brEnq) + int'(genEnq[0]) + int'(genEnq[1]);
    if (mn > 0) begin
      meb = 0; mgi = 0; mebt = 0; meg[0] = 0; meg[1] = 0;
      for (int k = 0; k < mn; k++) begin
        if (dq.size() == 0) check("R3 unexpected dispatch", 1, 0);
        else begin
          mv = dq.pop_front();
          if (mv >= 16) begin meb = 1; mebt = mv - 16; end
          else if (mgi < 2) begin meg[mgi] = mv; mgi++; end
        end
      end
      check("R5 branch strobe", int'(brEnq), int'(meb));
      if (meb) check("R3 branch tag", int'(brTag), mebt);
      check("R4 general lanes", int'(genEnq), (mgi == 2) ? 3 : mgi);
      if (mgi > 0) check("R3 general tag lane0", int'(genTag0), meg[0]);
      if (mgi > 1) check("R3 general tag lane1", int'(genTag1), meg[1]);
      dispSeen += mn;
    end
    mn = int'(retVld[0]) + int'(retVld[1]);
    for (int k = 0; k < mn; k++) begin
      if (rq.size() == 0) check("R8 unexpected retire", 1, 0);
      else check("R8 retire tag", int'(k == 0 ? retTag0 : retTag1), rq.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      nVec++; nBad++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  int prog[20];
  int base, idx, guard;

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    look();
    // R1 reset state
    check("R1 fetchRdy", int'(fetchRdy), 1);
    check("R1 brEnq", int'(brEnq), 0);
    check("R1 genEnq", int'(genEnq), 0);
    check("R1 retVld", int'(retVld), 0);
    check("R1 flush", int'(flush), 0);

    // phase 1: four general, two per cycle (R2, R3, R4)
    rq.push_back(0); rq.push_back(1); rq.push_back(2); rq.push_back(3);
    step(); fetchGrp(4, 4'b0000);
    look(); check("R4 two general", int'(genEnq), 3);
    step(); look(); check("R4 two general again", int'(genEnq), 3);
    step(); look(); check("R3 buffer drained", int'(genEnq), 0);
    // out-of-order finish, in-order retire (R8)
    step(); finVld = 2'b11; finTag = {4'd2, 4'd3};
    step(); finVld = 2'b01; finTag = {4'd0, 4'd0};
    look(); check("R8 head not done", int'(retVld), 0);
    step(); finVld = 2'b01; finTag = {4'd0, 4'd1};
    look(); check("R8 head only", int'(retVld), 1);
    step(); finVld = 2'b00;
    look(); check("R8 two retire", int'(retVld), 3);
    step(); look(); check("R8 last retire", int'(retVld), 1);
    step(); look(); check("R8 ring empty", int'(retVld), 0);

    // phase 2: branch limit and in-order hold (R5, R6)
    rq.push_back(4); rq.push_back(5);
    step(); fetchGrp(4, 4'b0011);
    look(); check("R5 one branch", int'(brEnq), 1);
    check("R6 younger held", int'(genEnq), 0);
    step(); look(); check("R5 second branch", int'(brEnq), 1);
    check("R4 general behind branch", int'(genEnq), 1);
    step(); look(); check("R4 last general", int'(genEnq), 1);
    check("R5 no branch", int'(brEnq), 0);

    // phase 3: full flag on older blocks younger branch (R6)
    step(); genFull = 1'b1; fetchGrp(2, 4'b0010);
    look(); check("R6 older blocked gen", int'(genEnq), 0);
    check("R6 younger branch held", int'(brEnq), 0);
    step(); genFull = 1'b0;
    look(); check("R6 released gen", int'(genEnq), 1);
    check("R6 released branch", int'(brEnq), 1);

    // phase 4: branch resolution and flush (R9, R10, R11)
    step(); genFull = 1'b1; fetchGrp(4, 4'b0000);
    finVld = 2'b01; finTag = {4'd0, 4'd4};
    step(); finVld = 2'b00;
    look(); check("R9 finish on branch ignored", int'(retVld), 0);
    check("R2 fetchRdy with four held", int'(fetchRdy), 1);
    step(); resVld = 1'b1; resMiss = 1'b0; resTag = 4'd4;
    step(); resVld = 1'b0;
    look(); check("R9 resolved branch retires", int'(retVld), 1);
    step(); resVld = 1'b1; resMiss = 1'b1; resTag = 4'd5; genFull = 1'b0;
    look(); check("R10 no dispatch in flush cycle", int'(genEnq), 0);
    check("R11 flush not yet", int'(flush), 0);
    dq.delete(); nextTag = 6;
    step(); resVld = 1'b0; resMiss = 1'b0;
    look(); check("R11 flush pulse", int'(flush), 1);
    check("R9 mispredicted branch retires", int'(retVld), 1);
    check("R10 buffer emptied", int'(genEnq), 0);
    step(); look(); check("R11 flush one cycle", int'(flush), 0);
    check("R10 buffer stays empty", int'(genEnq), 0);

    // phase 5: ring capacity (R7, R2), tags restart at branch+1 (R10)
    base = dispSeen;
    for (int j = 0; j < 20; j++) begin
      prog[j] = (6 + j) % 14;
      rq.push_back(prog[j]);
    end
    for (int g = 0; g < 5; g++) begin
      step();
      guard = 0;
      while (!fetchRdy && guard < 100) begin step(); guard++; end
      fetchGrp(4, 4'b0000);
    end
    repeat (8) step();
    look(); check("R7 ring full stalls", int'(genEnq), 0);
    check("R2 fetchRdy low with six held", int'(fetchRdy), 0);
    check("R7 fourteen allocated", dispSeen - base, 14);
    step(); finVld = 2'b01; finTag = {4'd0, 4'(prog[0])};
    step(); finVld = 2'b00;
    look(); check("R8 head retires", int'(retVld), 1);
    step(); look(); check("R7 one slot one dispatch", int'(genEnq), 1);
    idx = 1; guard = 0;
    while (idx < 20 && guard < 300) begin
      step();
      finVld = 2'b00;
      if (dispSeen - base > idx) begin
        finTag[3:0] = 4'(prog[idx]); finVld[0] = 1'b1; idx++;
        if (dispSeen - base > idx) begin
          finTag[7:4] = 4'(prog[idx]); finVld[1] = 1'b1; idx++;
        end
      end
      guard++;
    end
    step(); finVld = 2'b00;
    repeat (10) step();
    look();
    check("R3 all expected dispatched", dq.size(), 0);
    check("R8 all expected retired", rq.size(), 0);
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule